// File: doc/BRIEF.md
# Fault Timer with Hiccup Restart

This block sits beside the switching sequencer of a quasi-resonant flyback controller and decides whether gate pulses may be issued at all. It watches a synchronized loop-fault flag (raised when the control loop can no longer hold its internal reference), strobes marking the rising and falling supply thresholds, and an overvoltage comparator. Loop faults that last less than one qualification window are treated as transients. A fault that lasts longer blanks the drive for the rest of a hiccup period. If the fault stays, the block repeats short pulse bursts at a low duty. If the fault clears during the blanked interval, the block waits for the next supply start strobe before it runs again.

All timing comes from a slow tick input. One qualification window is `TICKS_PER_UNIT` ticks, and a full hiccup period is `PERIOD_UNITS` such windows. While the window is being measured, frequency control is handed from the oscillator back to free-running valley switching. An overvoltage event latches the drive off until the supply collapses.

Top module: `hiccup_supervisor`

## Requirements
- R1: After reset the state code is 0 (supply-off), and drive_en, vco_bypass and ovp_seen are all 0.
- R2: In the supply-off state the drive stays disabled whatever the fault flag does. A uv_high strobe moves the block to the running state (code 1), with drive_en at 1 from the next cycle.
- R3: A uv_low strobe in any state other than the overvoltage latch moves the block to the supply-off state on the next cycle, and the drive is disabled.
- R4: In the running state a high fault flag moves the block to the qualifying state (code 2) on the next cycle. In that state drive_en stays 1 and vco_bypass is 1. vco_bypass is 0 in every other state.
- R5: If the fault flag drops while qualifying, the block returns to the running state on the next cycle and the tick count is discarded. A later fault needs a full window again.
- R6: If the fault flag stays high for TICKS_PER_UNIT ticks in the qualifying state, the block enters the blanked state (code 3) in the cycle after the last of those ticks, and drive_en is 0.
- R7: With the fault still high, the blanked state lasts (PERIOD_UNITS-1)*TICKS_PER_UNIT ticks and then returns to qualifying. A persistent fault therefore gives pulses during 1 unit out of every PERIOD_UNITS units.
- R8: If the fault flag drops while blanked, the block moves on the next cycle to the wait-for-start state (code 4) with the drive still off. It stays there until a uv_high strobe sends it to the running state.
- R9: A high ovp input in any state other than the latch moves the block to the overvoltage latch (code 5) on the next cycle with drive_en at 0. ovp_seen then goes to 1 and stays at 1 until reset.
- R10: In the overvoltage latch, uv_high strobes, the fault flag and ovp going low have no effect. Only a uv_low strobe moves the block to the supply-off state.
- R11: When ovp and a uv_low strobe arrive in the same cycle, ovp wins. A uv_low strobe takes priority over every fault-timer or start transition.
- R12: The state code on state_o follows the encoding in R1 to R10, and the outputs track a cycle model of those rules under random stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Slow time-base strobe, one cycle wide |
| fault_flag | input | 1 | Synchronized loss-of-regulation flag |
| uv_high | input | 1 | Supply reached its start threshold (strobe) |
| uv_low | input | 1 | Supply fell below its stop threshold (strobe) |
| ovp | input | 1 | Overvoltage comparator output |
| drive_en | output | 1 | Allows the sequencer to issue gate pulses |
| vco_bypass | output | 1 | Hands frequency control back to free-running mode |
| state_o | output | 3 | Current state code |
| ovp_seen | output | 1 | Sticky overvoltage-event flag |

## Verification
The hardest situation to reach is a recovery that ends the blanked interval early, followed by a restart that waits for the supply strobe. To get there, the fault must stay high through a whole qualification window, then drop at an arbitrary point inside the long blanked interval, and only then may a uv_high strobe arrive. Directed sequences with a tick on every cycle place the fault drop at known offsets and also hit the exact boundary ticks of both windows. A random phase changes the fault flag slowly, so that windows do complete, and mixes in sparse supply and overvoltage strobes. A cycle model in the bench checks every state, every output and the sticky flag.

// File: rtl/hiccup_pkg.sv
package hiccup_pkg;

  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_RUN   = 3'd1,
    ST_QUAL  = 3'd2,
    ST_BLANK = 3'd3,
    ST_WAIT  = 3'd4,
    ST_OVP   = 3'd5
  } hcp_state_t;

  // number of whole units the drive stays blanked inside one hiccup period
  function automatic int blank_units(input int period_units);
    return period_units - 1;
  endfunction

  // states in which gate pulses may be issued
  function automatic logic drive_allowed(input hcp_state_t s);
    return (s == ST_RUN) || (s == ST_QUAL);
  endfunction

endpackage

// File: rtl/hcp_unit_timer.sv
module hcp_unit_timer #(
  parameter int TICKS_PER_UNIT = 128,
  parameter int UNITS_MAX      = 8,
  localparam int SW = (TICKS_PER_UNIT > 1) ? $clog2(TICKS_PER_UNIT) : 1,
  localparam int UW = $clog2(UNITS_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          tick,
  output logic          unit_pulse,
  output logic [UW-1:0] units
);

  logic [SW-1:0] sub_q;

  assign unit_pulse = tick && (sub_q == SW'(TICKS_PER_UNIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q <= '0;
      units <= '0;
    end else if (clr) begin
      sub_q <= '0;
      units <= '0;
    end else if (tick) begin
      if (unit_pulse) begin
        sub_q <= '0;
        if (units != UW'(UNITS_MAX)) units <= units + 1'b1;
      end else begin
        sub_q <= sub_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/hcp_fsm.sv
module hcp_fsm
  import hiccup_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fault,
  input  logic       uv_high,
  input  logic       uv_low,
  input  logic       ovp,
  input  logic       qual_done,
  input  logic       blank_done,
  output hcp_state_t state,
  output logic       timer_clr,
  output logic       ovp_seen
);

  hcp_state_t nxt;

  always_comb begin
    nxt = state;
    if (state != ST_OVP && ovp)         nxt = ST_OVP;
    else if (state != ST_OVP && uv_low) nxt = ST_OFF;
    else begin
      unique case (state)
        ST_OFF:   if (uv_high) nxt = ST_RUN;
        ST_RUN:   if (fault)   nxt = ST_QUAL;
        ST_QUAL:  if (!fault) nxt = ST_RUN;
                  else if (qual_done) nxt = ST_BLANK;
        ST_BLANK: if (!fault) nxt = ST_WAIT;
                  else if (blank_done) nxt = ST_QUAL;
        ST_WAIT:  if (uv_high) nxt = ST_RUN;
        ST_OVP:   if (uv_low)  nxt = ST_OFF;
        default:  nxt = ST_OFF;
      endcase
    end
  end

  assign timer_clr = (nxt != state);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OFF;
      ovp_seen <= 1'b0;
    end else begin
      state <= nxt;
      if (nxt == ST_OVP) ovp_seen <= 1'b1;
    end
  end

endmodule

// File: rtl/hiccup_supervisor.sv
module hiccup_supervisor
  import hiccup_pkg::*;
#(
  parameter int TICKS_PER_UNIT = 128,
  parameter int PERIOD_UNITS   = 8,
  localparam int UW = $clog2(PERIOD_UNITS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       fault_flag,
  input  logic       uv_high,
  input  logic       uv_low,
  input  logic       ovp,
  output logic       drive_en,
  output logic       vco_bypass,
  output logic [2:0] state_o,
  output logic       ovp_seen
);

  hcp_state_t    state;
  logic          timer_clr;
  logic          unit_pulse;
  logic [UW-1:0] units;

  // named internal events
  logic qual_done;
  logic blank_done;

  hcp_unit_timer #(
    .TICKS_PER_UNIT(TICKS_PER_UNIT),
    .UNITS_MAX     (PERIOD_UNITS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (timer_clr),
    .tick      (tick),
    .unit_pulse(unit_pulse),
    .units     (units)
  );

  assign qual_done  = unit_pulse && (units == '0);
  assign blank_done = unit_pulse && (units == UW'(blank_units(PERIOD_UNITS) - 1));

  hcp_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .fault     (fault_flag),
    .uv_high   (uv_high),
    .uv_low    (uv_low),
    .ovp       (ovp),
    .qual_done (qual_done),
    .blank_done(blank_done),
    .state     (state),
    .timer_clr (timer_clr),
    .ovp_seen  (ovp_seen)
  );

  assign drive_en   = drive_allowed(state);
  assign vco_bypass = (state == ST_QUAL);
  assign state_o    = state;

endmodule

// File: rtl/hiccup_supervisor_chk.sv
module hiccup_supervisor_chk
  import hiccup_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       uv_high,
  input logic       uv_low,
  input logic       ovp,
  input logic       drive_en,
  input logic       vco_bypass,
  input logic [2:0] state_o,
  input logic       ovp_seen
);

  // R9
  ovp_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp && state_o != 3'(ST_OVP)) |=> (state_o == 3'(ST_OVP) && !drive_en));

  // R10
  ovp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 3'(ST_OVP) && !uv_low) |=> (state_o == 3'(ST_OVP)));

  // R9
  ovp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_seen |=> ovp_seen);

  // R3
  uvlo_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (uv_low && !ovp && state_o != 3'(ST_OVP)) |=> (state_o == 3'(ST_OFF) && !drive_en));

  // R4
  bypass_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vco_bypass |-> drive_en);

  // R2
  drive_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_en) |-> ($past(uv_high) || $past(state_o) == 3'(ST_BLANK)));

endmodule

bind hiccup_supervisor hiccup_supervisor_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .uv_high   (uv_high),
  .uv_low    (uv_low),
  .ovp       (ovp),
  .drive_en  (drive_en),
  .vco_bypass(vco_bypass),
  .state_o   (state_o),
  .ovp_seen  (ovp_seen)
);

// File: tb/hiccup_supervisor_test.sv
module hiccup_supervisor_test;

  localparam int CLK_PERIOD = 10;
  localparam int TPU        = 5;
  localparam int PER        = 8;
  localparam int BLANK_TICKS = TPU * (PER - 1);

  localparam int S_OFF = 0, S_RUN = 1, S_QUAL = 2, S_BLANK = 3, S_WAIT = 4, S_OVP = 5;

  logic clk = 0, rst_n = 0, tick = 0, fault_flag = 0, uv_high = 0, uv_low = 0, ovp = 0;
  logic drive_en, vco_bypass, ovp_seen;
  logic [2:0] state_o;

  int n_cmp = 0, n_bad = 0;
  int m_state = S_OFF, m_cnt = 0;
  bit m_seen = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hiccup_supervisor #(.TICKS_PER_UNIT(TPU), .PERIOD_UNITS(PER)) uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .fault_flag(fault_flag),
    .uv_high(uv_high), .uv_low(uv_low), .ovp(ovp),
    .drive_en(drive_en), .vco_bypass(vco_bypass), .state_o(state_o), .ovp_seen(ovp_seen));

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // cycle model written from the requirements
  function automatic int model_next(int s, bit f, bit uh, bit ul, bit ov, bit tk, int cnt);
    if (s != S_OVP && ov) return S_OVP;
    if (s != S_OVP && ul) return S_OFF;
    case (s)
      S_OFF:   return uh ? S_RUN : S_OFF;
      S_RUN:   return f ? S_QUAL : S_RUN;
      S_QUAL:  if (!f) return S_RUN;
               else return (tk && cnt + 1 == TPU) ? S_BLANK : S_QUAL;
      S_BLANK: if (!f) return S_WAIT;
               else return (tk && cnt + 1 == BLANK_TICKS) ? S_QUAL : S_BLANK;
      S_WAIT:  return uh ? S_RUN : S_WAIT;
      default: return ul ? S_OFF : S_OVP;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = S_OFF; m_cnt = 0; m_seen = 0;
    end else begin
      int nx;
      nx = model_next(m_state, fault_flag, uv_high, uv_low, ovp, tick, m_cnt);
      if (nx != m_state) m_cnt = 0;
      else if (tick) m_cnt++;
      if (nx == S_OVP) m_seen = 1;
      m_state = nx;
    end
  end

  // R12: every cycle, outputs against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R12 model state", int'(state_o), m_state);
      chk("R12 model drive", int'(drive_en), int'(m_state == S_RUN || m_state == S_QUAL));
      chk("R12 model bypass", int'(vco_bypass), int'(m_state == S_QUAL));
      chk("R12 model ovp_seen", int'(ovp_seen), int'(m_seen));
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_uvh();
    uv_high = 1; cyc(1); uv_high = 0;
  endtask

  task automatic pulse_uvl();
    uv_low = 1; cyc(1); uv_low = 0;
  endtask

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
  end

  initial begin
    process::self().srandom(32'd1205);
    cyc(3);
    rst_n = 1;
    cyc(1);
    // R1
    chk("R1 state", int'(state_o), S_OFF);
    chk("R1 drive", int'(drive_en), 0);
    chk("R1 bypass", int'(vco_bypass), 0);
    chk("R1 ovp_seen", int'(ovp_seen), 0);

    tick = 1;
    fault_flag = 1; cyc(4);
    chk("R2 fault ignored while off", int'(drive_en), 0);
    fault_flag = 0; cyc(1);
    pulse_uvh();
    chk("R2 start strobe", int'(state_o), S_RUN);
    chk("R2 drive on", int'(drive_en), 1);

    fault_flag = 1; cyc(1);
    chk("R4 qualifying", int'(state_o), S_QUAL);
    chk("R4 bypass", int'(vco_bypass), 1);
    chk("R4 drive kept", int'(drive_en), 1);
    cyc(3);
    fault_flag = 0; cyc(1);
    chk("R5 back to run", int'(state_o), S_RUN);
    chk("R5 bypass off", int'(vco_bypass), 0);
    fault_flag = 1; cyc(1);
    cyc(TPU - 1);
    chk("R5 full window again", int'(state_o), S_QUAL);
    cyc(1);
    chk("R6 blanked", int'(state_o), S_BLANK);
    chk("R6 drive off", int'(drive_en), 0);
    cyc(BLANK_TICKS - 1);
    chk("R7 still blanked", int'(state_o), S_BLANK);
    cyc(1);
    chk("R7 burst restart", int'(state_o), S_QUAL);
    chk("R7 burst drive", int'(drive_en), 1);
    cyc(TPU);
    chk("R7 blanked again", int'(state_o), S_BLANK);
    cyc(10);
    fault_flag = 0; cyc(1);
    chk("R8 early exit", int'(state_o), S_WAIT);
    chk("R8 drive off", int'(drive_en), 0);
    cyc(BLANK_TICKS);
    chk("R8 waits for start", int'(state_o), S_WAIT);
    pulse_uvh();
    chk("R8 restart", int'(state_o), S_RUN);

    pulse_uvl();
    chk("R3 supply collapse", int'(state_o), S_OFF);
    chk("R3 drive off", int'(drive_en), 0);
    pulse_uvh();

    ovp = 1; uv_low = 1; cyc(1); ovp = 0; uv_low = 0;
    chk("R11 ovp wins", int'(state_o), S_OVP);
    chk("R9 sticky set", int'(ovp_seen), 1);
    chk("R9 drive off", int'(drive_en), 0);
    pulse_uvh();
    fault_flag = 1; cyc(3); fault_flag = 0;
    chk("R10 latch holds", int'(state_o), S_OVP);
    pulse_uvl();
    chk("R10 cleared by collapse", int'(state_o), S_OFF);
    chk("R9 sticky kept", int'(ovp_seen), 1);

    pulse_uvh();
    fault_flag = 1; cyc(2);
    uv_high = 1; uv_low = 1; cyc(1); uv_high = 0; uv_low = 0;
    chk("R11 collapse over timer", int'(state_o), S_OFF);
    pulse_uvh(); cyc(2);
    ovp = 1; cyc(1); ovp = 0;
    chk("R9 from qualifying", int'(state_o), S_OVP);
    fault_flag = 0;

    // random phase with a fresh reset
    rst_n = 0; cyc(2); rst_n = 1; cyc(1);
    chk("R1 ovp_seen cleared", int'(ovp_seen), 0);
    for (int i = 0; i < 6000; i++) begin
      tick       = ($urandom_range(0, 1) == 1);
      if ($urandom_range(0, 59) == 0) fault_flag = ~fault_flag;
      uv_high    = ($urandom_range(0, 24) == 0);
      uv_low     = ($urandom_range(0, 299) == 0);
      ovp        = ($urandom_range(0, 499) == 0);
      cyc(1);
    end
    tick = 0; uv_high = 0; uv_low = 0; ovp = 0;
    cyc(2);
    summary();
  end

endmodule